// File: doc/BRIEF.md
# Synchronized Multichannel Sampling Sequencer

This block runs one acquisition group for a motor-current front end. All channels of the group are tracked together during a fixed acquisition window and then held at the same instant. An external converter is then driven channel by channel through a start/done handshake. The converter returns an offset-binary code, which the block stores as a twos complement value in a separate result register for each channel. When the last channel of the group has been stored, the block raises an interrupt.

A group can be started in three ways: by a software command written to the control register, by a rising edge on the external convert-start pin, or by the PWM period synchronization pulse. The pin and the pulse each have their own enable bit. The host reads the result registers in any order. All result registers of a group are loaded on the same clock edge, so a read never mixes two groups. A trigger that arrives while a group is running is dropped and recorded in a sticky overrun flag.

Top module: `samp_seq_top`

## Requirements
- R1: After synchronous reset, busy, irq, sh_track and cvt_start are low, and the control, status and all four result registers read 0.
- R2: Control register (address 0) fields: bits[1:0] group size code, bit2 enables the external start pin, bit3 enables the PWM sync pulse, and bit4 is a write-only go command. A write with bit4 set starts a group. A rising edge of ext_start starts a group only while bit2 is set. A high pwm_sync sample starts a group only while bit3 is set. A disabled trigger has no effect.
- R3: busy and sh_track go high on the clock edge after the one that samples the trigger. sh_track stays high for exactly 20 cycles.
- R4: Size code 0 selects 2 channels, 1 selects 3, and 2 or 3 select 4. busy stays high for exactly 20 + 40·n cycles (100, 140 or 180).
- R5: Each channel has a 40-cycle conversion slot. cvt_start is a one-cycle pulse that opens each slot; the first pulse rises on the edge where sh_track falls. cvt_chan runs 0, 1, … n-1.
- R6: The code returned with cvt_done during slot k is stored with its MSB inverted (offset binary to twos complement) and is read at address 4+k.
- R7: The result registers of a group all change on the edge where busy falls. Before that edge they show the previous group. Channels at or beyond n keep their old values.
- R8: irq rises on the edge where busy falls. The status register (address 1) reads bit0 done (the irq state), bit1 overrun and bit2 busy. A status read clears done and overrun after returning them, but a set in the same cycle takes priority over the clear.
- R9: A trigger accepted while busy is ignored, so the group length is unchanged, and it sets the sticky overrun flag.
- R10: The group size is latched at start. Rewriting the size field during a group does not change that group.
- R11: Read data appears on h_rdata on the cycle after the read strobe. Registers can be read in any order. The control register reads back bits[3:0] with bit4 as 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host write strobe |
| hr_en | input | 1 | Host read strobe |
| h_addr | input | 4 | Host register address |
| h_wdata | input | 12 | Host write data |
| h_rdata | output | 12 | Registered host read data |
| ext_start | input | 1 | External convert-start pin (rising edge) |
| pwm_sync | input | 1 | PWM period synchronization pulse |
| sh_track | output | 1 | High while the sample-and-holds track; falling edge is the hold instant |
| cvt_start | output | 1 | One-cycle start pulse to the converter |
| cvt_chan | output | 2 | Channel the converter should convert |
| cvt_done | input | 1 | Converter result-valid strobe |
| cvt_code | input | 12 | Converter offset-binary result |
| busy | output | 1 | A group is in progress |
| irq | output | 1 | Group-complete interrupt |

## Verification
Groups of every size are started from each of the three trigger sources, with random converter codes and random result-read orders. These runs separate slot-count errors from trigger-path errors and catch channel-index mix-ups. Directed codes 0x000, 0xFFF and 0x800 check the sign conversion at its extremes. One group carries a mid-run go command, a mid-run size rewrite and a mid-run result read, which together separate dropped triggers, the latched size and the group-atomic result update from their broken alternatives. Disabled triggers are pulsed while the block is idle to show that they start nothing.

// File: rtl/samp_pkg.sv
package samp_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACQ  = 2'd1,
    SQ_CONV = 2'd2
  } sq_state_e;

  // register addresses
  localparam int RA_CTRL = 0;
  localparam int RA_STAT = 1;
  localparam int RA_RES  = 4;

  // control bit positions
  localparam int CB_EXT = 2;
  localparam int CB_PWM = 3;
  localparam int CB_GO  = 4;

endpackage

// File: rtl/seq_trigger.sv
module seq_trigger (
  input  logic clk,
  input  logic rst,
  input  logic sw_go,
  input  logic ext_start,
  input  logic pwm_sync,
  input  logic ext_en,
  input  logic pwm_en,
  output logic start_pulse
);

  logic ext_q;
  logic ext_rise;

  assign ext_rise = ext_start & ~ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q       <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      ext_q       <= ext_start;
      start_pulse <= sw_go | (ext_en & ext_rise) | (pwm_en & pwm_sync);
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import samp_pkg::*;
#(
  parameter int MAX_CH   = 4,
  parameter int ACQ_CYC  = 20,
  parameter int CONV_CYC = 40
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_pulse,
  input  logic [1:0]                 size_code,
  output logic                       busy,
  output logic                       sh_track,
  output logic                       cvt_start,
  output logic [$clog2(MAX_CH)-1:0]  cvt_chan,
  output logic                       conv_active,
  output logic [$clog2(MAX_CH)-1:0]  last_chan,
  output logic                       commit,
  output logic                       overrun_set
);

  localparam int CH_W    = $clog2(MAX_CH);
  localparam int CNT_TOP = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  sq_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   chan_q;
  logic [CH_W-1:0]   last_q;
  logic [CH_W-1:0]   last_dec;
  logic              start_q;
  logic              acq_end;
  logic              slot_end;
  int                want;

  // size code -> index of last channel (0:2ch, 1:3ch, 2/3:4ch)
  always_comb begin
    want = int'(size_code) + 1;
    if (want > 3) want = 3;
    if (want > MAX_CH - 1) want = MAX_CH - 1;
    last_dec = CH_W'(want);
  end

  assign acq_end     = (state_q == SQ_ACQ)  && (cnt_q == CNT_W'(ACQ_CYC - 1));
  assign slot_end    = (state_q == SQ_CONV) && (cnt_q == CNT_W'(CONV_CYC - 1));
  assign commit      = slot_end && (chan_q == last_q);
  assign overrun_set = start_pulse && (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      chan_q  <= '0;
      last_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_pulse) begin
            state_q <= SQ_ACQ;
            cnt_q   <= '0;
            chan_q  <= '0;
            last_q  <= last_dec;
          end
        end
        SQ_ACQ: begin
          if (acq_end) begin
            state_q <= SQ_CONV;
            cnt_q   <= '0;
            chan_q  <= '0;
            start_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_CONV: begin
          if (slot_end) begin
            cnt_q <= '0;
            if (chan_q == last_q) begin
              state_q <= SQ_IDLE;
            end else begin
              chan_q  <= chan_q + 1'b1;
              start_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != SQ_IDLE);
  assign sh_track    = (state_q == SQ_ACQ);
  assign conv_active = (state_q == SQ_CONV);
  assign cvt_start   = start_q;
  assign cvt_chan    = chan_q;
  assign last_chan   = last_q;

endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int DATA_W = 12,
  parameter int MAX_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cap_en,
  input  logic [$clog2(MAX_CH)-1:0]  cap_chan,
  input  logic [DATA_W-1:0]          cap_code,
  input  logic                       commit,
  input  logic [$clog2(MAX_CH)-1:0]  last_chan,
  input  logic [$clog2(MAX_CH)-1:0]  rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic [MAX_CH*DATA_W-1:0]   res_flat
);

  localparam int CH_W = $clog2(MAX_CH);
  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] cap_twos;
  assign cap_twos = cap_code ^ SIGN_FLIP;

  for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
    logic [DATA_W-1:0] shd_q;
    logic [DATA_W-1:0] vis_q;
    logic              hit;

    assign hit = cap_en && (cap_chan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_q <= '0;
        vis_q <= '0;
      end else begin
        if (hit) shd_q <= cap_twos;
        if (commit && (CH_W'(g) <= last_chan)) vis_q <= hit ? cap_twos : shd_q;
      end
    end

    assign res_flat[g*DATA_W +: DATA_W] = vis_q;
  end

  assign rd_data = res_flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/samp_seq_top.sv
module samp_seq_top
  import samp_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 4,
  parameter int MAX_CH   = 4,
  parameter int ACQ_CYC  = 20,
  parameter int CONV_CYC = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hw_en,
  input  logic                      hr_en,
  input  logic [ADDR_W-1:0]         h_addr,
  input  logic [DATA_W-1:0]         h_wdata,
  output logic [DATA_W-1:0]         h_rdata,
  input  logic                      ext_start,
  input  logic                      pwm_sync,
  output logic                      sh_track,
  output logic                      cvt_start,
  output logic [$clog2(MAX_CH)-1:0] cvt_chan,
  input  logic                      cvt_done,
  input  logic [DATA_W-1:0]         cvt_code,
  output logic                      busy,
  output logic                      irq
);

  localparam int CH_W = $clog2(MAX_CH);

  logic [3:0]               ctrl_q;
  logic                     done_q;
  logic                     ovr_q;
  logic                     wr_ctrl;
  logic                     sw_go;
  logic                     rd_status;
  logic                     res_sel;
  logic [CH_W-1:0]          rd_idx;
  logic [DATA_W-1:0]        bank_rd;
  logic [DATA_W-1:0]        rd_mux;
  logic                     start_pulse;
  logic                     conv_active;
  logic [CH_W-1:0]          last_chan;
  logic                     commit;
  logic                     overrun_set;
  logic [MAX_CH*DATA_W-1:0] res_flat;

  assign wr_ctrl   = hw_en && (int'(h_addr) == RA_CTRL);
  assign sw_go     = wr_ctrl && h_wdata[CB_GO];
  assign rd_status = hr_en && (int'(h_addr) == RA_STAT);
  assign res_sel   = (int'(h_addr) >= RA_RES) && (int'(h_addr) < RA_RES + MAX_CH);
  assign rd_idx    = CH_W'(int'(h_addr) - RA_RES);

  seq_trigger u_trig (
    .clk         (clk),
    .rst         (rst),
    .sw_go       (sw_go),
    .ext_start   (ext_start),
    .pwm_sync    (pwm_sync),
    .ext_en      (ctrl_q[CB_EXT]),
    .pwm_en      (ctrl_q[CB_PWM]),
    .start_pulse (start_pulse)
  );

  seq_ctrl #(
    .MAX_CH   (MAX_CH),
    .ACQ_CYC  (ACQ_CYC),
    .CONV_CYC (CONV_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_pulse (start_pulse),
    .size_code   (ctrl_q[1:0]),
    .busy        (busy),
    .sh_track    (sh_track),
    .cvt_start   (cvt_start),
    .cvt_chan    (cvt_chan),
    .conv_active (conv_active),
    .last_chan   (last_chan),
    .commit      (commit),
    .overrun_set (overrun_set)
  );

  result_bank #(
    .DATA_W (DATA_W),
    .MAX_CH (MAX_CH)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (conv_active && cvt_done),
    .cap_chan  (cvt_chan),
    .cap_code  (cvt_code),
    .commit    (commit),
    .last_chan (last_chan),
    .rd_idx    (rd_idx),
    .rd_data   (bank_rd),
    .res_flat  (res_flat)
  );

  always_comb begin
    rd_mux = '0;
    if (int'(h_addr) == RA_CTRL)      rd_mux = DATA_W'(ctrl_q);
    else if (int'(h_addr) == RA_STAT) rd_mux = DATA_W'({busy, ovr_q, done_q});
    else if (res_sel)                 rd_mux = bank_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      h_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= h_wdata[3:0];
      if (commit)         done_q <= 1'b1;
      else if (rd_status) done_q <= 1'b0;
      if (overrun_set)    ovr_q <= 1'b1;
      else if (rd_status) ovr_q <= 1'b0;
      if (hr_en) h_rdata <= rd_mux;
    end
  end

  assign irq = done_q;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int DATA_W   = 12,
  parameter int MAX_CH   = 4,
  parameter int ACQ_CYC  = 20,
  parameter int CONV_CYC = 40
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     busy,
  input logic                     sh_track,
  input logic                     cvt_start,
  input logic                     irq,
  input logic                     start_pulse,
  input logic                     rd_status,
  input logic                     ovr_flag,
  input logic [MAX_CH*DATA_W-1:0] res_flat
);

  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  // R4: a finished group lasted one of the legal lengths
  always_ff @(posedge clk) begin
    if (!rst && !busy && run_len != 16'd0) begin
      a_r4_group_len: assert (int'(run_len) == ACQ_CYC + 2*CONV_CYC ||
                              int'(run_len) == ACQ_CYC + 3*CONV_CYC ||
                              int'(run_len) == ACQ_CYC + 4*CONV_CYC)
        else $error("group length %0d", run_len);
    end
  end

  a_r3_track_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sh_track);

  a_r5_start_in_slot: assert property (@(posedge clk) disable iff (rst)
    cvt_start |-> (busy && !sh_track));

  a_r8_irq_on_finish: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  a_r8_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    rd_status |=> (!irq || $rose(irq)));

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && busy) |=> ovr_flag);

  a_r7_results_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(res_flat));

endmodule

bind samp_seq_top seq_checker #(
  .DATA_W   (DATA_W),
  .MAX_CH   (MAX_CH),
  .ACQ_CYC  (ACQ_CYC),
  .CONV_CYC (CONV_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .sh_track    (sh_track),
  .cvt_start   (cvt_start),
  .irq         (irq),
  .start_pulse (start_pulse),
  .rd_status   (rd_status),
  .ovr_flag    (ovr_q),
  .res_flat    (res_flat)
);

// File: tb/samp_seq_top_test.sv
module samp_seq_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_LAT   = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_en = 1'b0;
  logic        hr_en = 1'b0;
  logic [3:0]  h_addr = '0;
  logic [11:0] h_wdata = '0;
  logic [11:0] h_rdata;
  logic        ext_start = 1'b0;
  logic        pwm_sync = 1'b0;
  logic        sh_track;
  logic        cvt_start;
  logic [1:0]  cvt_chan;
  logic        cvt_done = 1'b0;
  logic [11:0] cvt_code = '0;
  logic        busy;
  logic        irq;

  int nchk = 0;
  int nerr = 0;

  logic [11:0] codes   [4];
  logic [11:0] exp_res [4];
  logic [1:0]  chan_log [256];
  int          chan_tot = 0;
  int          sh_tot = 0;
  bit          fixed_codes = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  samp_seq_top uut (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hr_en(hr_en), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .ext_start(ext_start),
    .pwm_sync(pwm_sync), .sh_track(sh_track), .cvt_start(cvt_start),
    .cvt_chan(cvt_chan), .cvt_done(cvt_done), .cvt_code(cvt_code),
    .busy(busy), .irq(irq)
  );

  // converter model: fixed latency after each start pulse
  initial begin
    forever begin
      @(negedge clk);
      cvt_done = 1'b0;
      if (cvt_start === 1'b1) begin
        automatic logic [1:0] ch = cvt_chan;
        repeat (CONV_LAT - 1) @(negedge clk);
        cvt_done = 1'b1;
        cvt_code = codes[ch];
      end
    end
  end

  // monitor of start pulses and tracking cycles
  initial begin
    forever begin
      @(negedge clk);
      if (cvt_start === 1'b1) begin
        chan_log[chan_tot & 255] = cvt_chan;
        chan_tot++;
      end
      if (sh_track === 1'b1) sh_tot++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  task automatic chk(input string req, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic host_write(input int a, input int d);
    hw_en = 1'b1; h_addr = 4'(a); h_wdata = 12'(d);
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic host_read(input int a, output int d);
    hr_en = 1'b1; h_addr = 4'(a);
    @(negedge clk);
    hr_en = 1'b0;
    d = int'(h_rdata);
  endtask

  function automatic int n_of(input int szc);
    return (szc == 0) ? 2 : (szc == 1) ? 3 : 4;
  endfunction

  function automatic int twos_of(input logic [11:0] c);
    return int'(c ^ 12'h800);
  endfunction

  // src: 0 software, 1 ext pin, 2 pwm sync
  task automatic run_group(input int szc, input int src, input bit inj_ovr,
                           input bit mid_read, input bit resize);
    int n, total, ctrl, cnt, sh_base, ch_base, rd, off, step;
    n = n_of(szc);
    total = 20 + 40 * n;
    if (!fixed_codes)
      for (int k = 0; k < 4; k++) codes[k] = 12'($urandom);
    ctrl = szc | ((src == 1) ? 4 : 0) | ((src == 2) ? 8 : 0);
    host_write(0, ctrl);
    sh_base = sh_tot;
    ch_base = chan_tot;
    if (src == 0) host_write(0, ctrl | 16);
    else if (src == 1) begin ext_start = 1'b1; @(negedge clk); end
    else begin pwm_sync = 1'b1; @(negedge clk); pwm_sync = 1'b0; end
    chk("R3 busy not yet high", int'(busy), 0);
    @(negedge clk);
    chk("R3 busy high", int'(busy), 1);
    chk("R3 track high", int'(sh_track), 1);
    cnt = 0;
    while (busy === 1'b1 && cnt < 400) begin
      cnt++;
      if (resize && cnt == 30) begin
        hw_en = 1'b1; h_addr = 4'd0; h_wdata = 12'((ctrl & 12) | ((szc == 2) ? 0 : 2));
      end
      if (resize && cnt == 31) hw_en = 1'b0;
      if (inj_ovr && cnt == 50) begin
        hw_en = 1'b1; h_addr = 4'd0; h_wdata = 12'(ctrl | 16);
      end
      if (inj_ovr && cnt == 51) hw_en = 1'b0;
      if (mid_read && cnt == 60) begin hr_en = 1'b1; h_addr = 4'd4; end
      if (mid_read && cnt == 61) begin
        hr_en = 1'b0;
        chk("R7 old result during group", int'(h_rdata), int'(exp_res[0]));
      end
      @(negedge clk);
    end
    ext_start = 1'b0;
    chk("R4 R9 R10 busy length", cnt, total);
    chk("R8 irq at finish", int'(irq), 1);
    chk("R3 track length", sh_tot - sh_base, 20);
    chk("R5 start pulse count", chan_tot - ch_base, n);
    for (int k = 0; k < n; k++)
      chk("R5 channel order", int'(chan_log[(ch_base + k) & 255]), k);
    for (int k = 0; k < n; k++) exp_res[k] = 12'(twos_of(codes[k]));
    off = int'($urandom % 4);
    step = ($urandom % 2 == 0) ? 1 : 3;
    for (int k = 0; k < 4; k++) begin
      automatic int idx = (off + k * step) & 3;
      host_read(4 + idx, rd);
      chk("R6 R7 R11 result register", rd, int'(exp_res[idx]));
    end
    host_read(1, rd);
    chk("R8 R9 status", rd, inj_ovr ? 3 : 1);
    chk("R8 irq cleared by status read", int'(irq), 0);
    host_read(1, rd);
    chk("R8 R9 status after clear", rd, 0);
  endtask

  initial begin
    int rd;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin exp_res[k] = '0; codes[k] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 track", int'(sh_track), 0);
    chk("R1 cvt_start", int'(cvt_start), 0);
    for (int a = 0; a < 8; a++) begin
      if (a == 2 || a == 3) continue;
      host_read(a, rd);
      chk("R1 register after reset", rd, 0);
    end

    // R2 disabled triggers do nothing
    host_write(0, 1);
    ext_start = 1'b1; pwm_sync = 1'b1;
    @(negedge clk);
    pwm_sync = 1'b0;
    repeat (3) @(negedge clk);
    ext_start = 1'b0;
    chk("R2 disabled trigger busy", int'(busy), 0);
    host_read(1, rd);
    chk("R2 disabled trigger status", rd, 0);

    // R11 readback and unmapped addresses
    host_write(0, 14);
    host_read(0, rd);
    chk("R11 control readback", rd, 14);
    host_write(0, 0);
    for (int a = 8; a < 16; a += 7) begin
      host_read(a, rd);
      chk("R11 unmapped read", rd, 0);
    end
    host_read(2, rd);
    chk("R11 unmapped read", rd, 0);

    // directed groups: each size and source
    run_group(3, 0, 1'b0, 1'b0, 1'b0);
    run_group(0, 1, 1'b0, 1'b0, 1'b0);
    run_group(1, 2, 1'b0, 1'b0, 1'b0);

    // R6 sign conversion extremes
    fixed_codes = 1'b1;
    codes[0] = 12'h000; codes[1] = 12'hFFF; codes[2] = 12'h800; codes[3] = 12'h7FF;
    run_group(2, 0, 1'b0, 1'b0, 1'b0);
    chk("R6 zero code", int'(exp_res[0]), 12'h800);
    fixed_codes = 1'b0;

    // R7 R9 R10 overrun, mid-group read and size rewrite
    run_group(2, 2, 1'b1, 1'b1, 1'b1);
    run_group(0, 0, 1'b1, 1'b1, 1'b1);

    // random groups
    for (int g = 0; g < 12; g++)
      run_group(int'($urandom % 4), int'($urandom % 3), 1'($urandom % 2), 1'b1, 1'($urandom % 2));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule